// File: doc/BRIEF.md
# Linear Congruential Video Noise Source

This block streams 10-bit pseudo-random pixel values for filling a picture with white noise. A 32-bit state register advances by a linear congruential step with multiplier 1664525 and increment 1013904223. Because the modulus is 2^32, the wrap costs no logic: the sum is simply cut to 32 bits. Each 32-bit word is cut into three 10-bit pixels taken from its upper thirty bits. The two lowest bits are discarded because they repeat with a very short period.

Pixels leave through a valid/ready pair. A pixel stays on the output until the consumer accepts it. The next state is computed only after all three pixels of the current word have been accepted. A seed strobe overwrites the state at any time, including in the middle of a multiply, and restarts the slicing at the top field. The state itself is the first word emitted.

A build-time switch selects how the 32x32 product is formed. The parallel form adds three 16x16 partial products in one cycle. The serial form feeds one 16x16 multiplier over four successive cycles: three partial products, then the increment. In both forms the high-half by high-half product is skipped, since it lands entirely above bit 31.

Top module: `vnoise_gen`

## Requirements
- R1: After the three pixels of a word with state s have been accepted, the next word emitted is (1664525*s + 1013904223) mod 2^32. Both multiplier variants produce the identical sequence.
- R2: The pixels of a word w are emitted in the order w[31:22], w[21:12], w[11:2]. Bits w[1:0] never appear on the output.
- R3: A synchronous active-high reset loads the state with RESET_SEED (default 32'h1234_5678). One cycle after reset, sample_valid is 1 and sample_data is RESET_SEED[31:22].
- R4: While sample_valid is 1 and sample_ready is 0, with no seed strobe, sample_valid stays 1 and sample_data is unchanged on the next cycle.
- R5: When seed_load is 1 at a clock edge, the state becomes seed_value, and on the next cycle the block presents seed_value[31:22] with sample_valid at 1. This holds even if a multiply was pending; the strobe aborts it.
- R6: Accepting the third pixel of a word drives sample_valid to 0 on the next cycle. No new word is started before that third acceptance.
- R7: After the third acceptance, sample_valid stays 0 for exactly 1 cycle in the parallel variant (SERIAL=0) and for exactly 5 cycles in the serial variant (SERIAL=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Strobe that overwrites the state with seed_value |
| seed_value | input | W (32) | New state value |
| sample_ready | input | 1 | Consumer accepts the presented pixel |
| sample_valid | output | 1 | A pixel is presented |
| sample_data | output | SW (10) | Pixel value |

## Verification
The hardest situation to reach is a seed strobe that collides with multiplier work already in flight. In the parallel variant the collision is the same edge that would load the fresh product. In the serial variant it falls in the middle of the four-step accumulation. The bench instantiates both variants side by side on shared stimulus and accepts three pixels back to back. It then raises the strobe at once, and again after two idle cycles, so that each variant is caught in a different phase of its update. An independent 64-bit model of the recurrence then checks that the seed, not the discarded product, comes out.

// File: rtl/vnoise_pkg.sv
package vnoise_pkg;
  localparam int unsigned STATE_W  = 32;
  localparam int unsigned PIXEL_W  = 10;
  localparam int unsigned PIXELS   = 3;
  localparam logic [31:0] MULT_K   = 32'd1664525;
  localparam logic [31:0] INCR_K   = 32'd1013904223;
  localparam logic [31:0] SEED_RST = 32'h1234_5678;
endpackage

// File: rtl/vnoise_mul_par.sv
// One-cycle (a*x + c) mod 2^W from half-width partial products.
module vnoise_mul_par #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] A = '0,
  parameter logic [W-1:0] C = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         start,
  input  logic [W-1:0] x,
  output logic         done,
  output logic [W-1:0] y
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0] term [4];
  logic [W-1:0] sum;

  for (genvar i = 0; i < 2; i++) begin : g_xi
    for (genvar j = 0; j < 2; j++) begin : g_aj
      localparam int unsigned SH = HALF * (i + j);
      if (SH < W) begin : g_keep
        logic [W-1:0] pp;
        assign pp = W'(x[i*HALF +: HALF]) * W'(A[j*HALF +: HALF]);
        assign term[i*2+j] = pp << SH;
      end else begin : g_skip
        assign term[i*2+j] = '0;
      end
    end
  end

  always_comb begin
    sum = C;
    for (int k = 0; k < 4; k++) sum = sum + term[k];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      done <= 1'b0;
      y    <= '0;
    end else begin
      done <= start;
      if (start) y <= sum;
    end
  end
endmodule

// File: rtl/vnoise_mul_seq.sv
// Four-cycle (a*x + c) mod 2^W on one half-width multiplier.
// x must stay stable while busy (it is the held state register).
module vnoise_mul_seq #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] A = '0,
  parameter logic [W-1:0] C = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         start,
  input  logic [W-1:0] x,
  output logic         done,
  output logic [W-1:0] y
);
  localparam int unsigned HALF = W / 2;

  logic [1:0]      step;
  logic            busy;
  logic [W-1:0]    acc;
  logic [HALF-1:0] opa, opb;
  logic [W-1:0]    mp, addend;

  always_comb begin
    opa    = step[1] ? x[W-1 -: HALF] : x[HALF-1:0];
    opb    = (step == 2'd1) ? A[W-1 -: HALF] : A[HALF-1:0];
    mp     = W'(opa) * W'(opb);
    if (step == 2'd3)      addend = C;
    else if (step == 2'd0) addend = mp;
    else                   addend = mp << HALF;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= '0;
      acc  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        step <= '0;
        acc  <= '0;
      end else if (busy) begin
        acc  <= acc + addend;
        step <= step + 2'd1;
        if (step == 2'd3) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign y = acc;
endmodule

// File: rtl/vnoise_slicer.sv
// Holds the state word and hands out its fields top-down over valid/ready.
module vnoise_slicer #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 10,
  parameter int unsigned NS = 3,
  parameter logic [W-1:0] RESET_WORD = '0,
  localparam int unsigned IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  word_in,
  input  logic          ready,
  output logic          valid,
  output logic [SW-1:0] data,
  output logic [W-1:0]  word,
  output logic [IW-1:0] idx,
  output logic          last_taken
);
  logic [SW-1:0] fld [NS];
  logic [IW-1:0] idx_nxt;

  for (genvar k = 0; k < NS; k++) begin : g_fld
    assign fld[k] = word[W-1-k*SW -: SW];
  end

  assign idx_nxt    = idx + 1'b1;
  assign last_taken = valid && ready && (idx == IW'(NS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      word  <= RESET_WORD;
      idx   <= '0;
      valid <= 1'b1;
      data  <= RESET_WORD[W-1 -: SW];
    end else if (load) begin
      word  <= word_in;
      idx   <= '0;
      valid <= 1'b1;
      data  <= word_in[W-1 -: SW];
    end else if (valid && ready) begin
      if (idx == IW'(NS - 1)) begin
        valid <= 1'b0;
      end else begin
        idx  <= idx_nxt;
        data <= fld[idx_nxt];
      end
    end
  end
endmodule

// File: rtl/vnoise_gen.sv
module vnoise_gen #(
  parameter int unsigned W  = vnoise_pkg::STATE_W,
  parameter int unsigned SW = vnoise_pkg::PIXEL_W,
  parameter int unsigned NS = vnoise_pkg::PIXELS,
  parameter bit SERIAL = 1'b0,
  parameter logic [W-1:0] A = vnoise_pkg::MULT_K,
  parameter logic [W-1:0] C = vnoise_pkg::INCR_K,
  parameter logic [W-1:0] RESET_SEED = vnoise_pkg::SEED_RST,
  localparam int unsigned IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          seed_load,
  input  logic [W-1:0]  seed_value,
  input  logic          sample_ready,
  output logic          sample_valid,
  output logic [SW-1:0] sample_data
);
  logic [W-1:0]  state, prod;
  logic          mul_done, mul_start, last_taken, load;
  logic [W-1:0]  word_in;
  logic [IW-1:0] field_idx;

  assign mul_start = last_taken && !seed_load;
  assign load      = seed_load || mul_done;
  assign word_in   = seed_load ? seed_value : prod;

  if (SERIAL) begin : g_ser
    vnoise_mul_seq #(.W(W), .A(A), .C(C)) u_mul (
      .clk(clk), .rst(rst), .clr(seed_load), .start(mul_start),
      .x(state), .done(mul_done), .y(prod));
  end else begin : g_par
    vnoise_mul_par #(.W(W), .A(A), .C(C)) u_mul (
      .clk(clk), .rst(rst), .clr(seed_load), .start(mul_start),
      .x(state), .done(mul_done), .y(prod));
  end

  vnoise_slicer #(.W(W), .SW(SW), .NS(NS), .RESET_WORD(RESET_SEED)) u_slice (
    .clk(clk), .rst(rst), .load(load), .word_in(word_in),
    .ready(sample_ready), .valid(sample_valid), .data(sample_data),
    .word(state), .idx(field_idx), .last_taken(last_taken));
endmodule

// File: rtl/vnoise_gen_chk.sv
module vnoise_gen_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 10,
  parameter int unsigned NS = 3,
  parameter logic [W-1:0] RESET_SEED = '0,
  localparam int unsigned IW = (NS > 1) ? $clog2(NS) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          seed_load,
  input logic [W-1:0]  seed_value,
  input logic          sample_ready,
  input logic          sample_valid,
  input logic [SW-1:0] sample_data,
  input logic [IW-1:0] field_idx
);
  p_reset_r3: assert property (@(posedge clk)
    rst |=> sample_valid && sample_data == RESET_SEED[W-1 -: SW]);

  p_seed_restart_r5: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> sample_valid && sample_data == $past(seed_value[W-1 -: SW]));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    sample_valid && !sample_ready && !seed_load |=> sample_valid && $stable(sample_data));

  p_update_wait_r6: assert property (@(posedge clk) disable iff (rst)
    sample_valid && sample_ready && !seed_load && field_idx == IW'(NS - 1)
    |=> !sample_valid);

  p_field_step_r2: assert property (@(posedge clk) disable iff (rst)
    sample_valid && sample_ready && !seed_load && field_idx != IW'(NS - 1)
    |=> sample_valid && field_idx == $past(field_idx) + 1'b1);
endmodule

bind vnoise_gen vnoise_gen_chk #(.W(W), .SW(SW), .NS(NS), .RESET_SEED(RESET_SEED)) u_chk (
  .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
  .sample_ready(sample_ready), .sample_valid(sample_valid),
  .sample_data(sample_data), .field_idx(field_idx));

// File: tb/vnoise_gen_tb.sv
`timescale 1ns/1ps
// Stream monitor: compares a DUT against an independent model of the recurrence.
module vnoise_gen_mon #(
  parameter int GAP = 1,
  parameter logic [31:0] RESET_SEED = 32'h1234_5678,
  parameter string NAME = "dut"
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        seed_load,
  input  logic [31:0] seed_value,
  input  logic        sample_ready,
  input  logic        sample_valid,
  input  logic [9:0]  sample_data,
  output int          n_chk,
  output int          n_fail
);
  logic [31:0] st;
  int idx = 0, gap = 0;
  bit in_gap = 0, chk_reset = 0, after_load = 0, hold_prev = 0;
  logic [9:0] prev_data;

  function automatic logic [31:0] model_next(input logic [31:0] s);
    logic [63:0] p;
    p = 64'(s) * 64'd1664525 + 64'd1013904223;
    return p[31:0];
  endfunction

  function automatic logic [9:0] model_field(input logic [31:0] s, input int k);
    return 10'((s >> (22 - 10 * k)) & 32'h3FF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, NAME, act, exp, $time);
    end
  endtask

  initial begin n_chk = 0; n_fail = 0; st = RESET_SEED; end

  always @(negedge clk) begin
    if (rst) begin
      st = RESET_SEED; idx = 0; in_gap = 0; chk_reset = 1;
      after_load = 0; hold_prev = 0;
    end else begin
      if (chk_reset) begin
        chk(sample_valid && sample_data == RESET_SEED[31:22], "R3",
            {sample_valid, sample_data}, {1'b1, RESET_SEED[31:22]});
        chk_reset = 0;
      end
      if (after_load) chk(sample_valid, "R5 valid after seed", sample_valid, 1);
      after_load = 0;
      if (hold_prev)
        chk(sample_valid && sample_data == prev_data, "R4",
            {sample_valid, sample_data}, {1'b1, prev_data});
      if (in_gap) begin
        if (sample_valid) begin
          chk(gap == GAP, "R6/R7 gap", gap, GAP);
          in_gap = 0;
        end else gap++;
      end
      if (sample_valid)
        chk(sample_data == model_field(st, idx), "R1/R2 data",
            sample_data, model_field(st, idx));
      hold_prev = sample_valid && !sample_ready && !seed_load;
      prev_data = sample_data;
      if (seed_load) begin
        st = seed_value; idx = 0; in_gap = 0; after_load = 1;
      end else if (sample_valid && sample_ready) begin
        if (idx == 2) begin
          st = model_next(st); idx = 0; in_gap = 1; gap = 0;
        end else idx++;
      end
    end
  end
endmodule

module vnoise_gen_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        seed_load = 0;
  logic [31:0] seed_value = '0;
  logic        sample_ready = 0;
  logic        v_par, v_ser;
  logic [9:0]  d_par, d_ser;
  int          c_par, f_par, c_ser, f_ser;
  int          n_own = 0, f_own = 0;

  always #2.5 clk = ~clk;

  // R1 both variants: parallel instance and serial instance share the stimulus
  vnoise_gen #(.SERIAL(1'b0)) u_dut (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
    .sample_ready(sample_ready), .sample_valid(v_par), .sample_data(d_par));
  vnoise_gen #(.SERIAL(1'b1)) u_dut_ser (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
    .sample_ready(sample_ready), .sample_valid(v_ser), .sample_data(d_ser));

  vnoise_gen_mon #(.GAP(1), .NAME("parallel")) u_mon_par (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
    .sample_ready(sample_ready), .sample_valid(v_par), .sample_data(d_par),
    .n_chk(c_par), .n_fail(f_par));
  vnoise_gen_mon #(.GAP(5), .NAME("serial")) u_mon_ser (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
    .sample_ready(sample_ready), .sample_valid(v_ser), .sample_data(d_ser),
    .n_chk(c_ser), .n_fail(f_ser));

  localparam int NVEC = 8;
  localparam logic [31:0] SEEDS [NVEC] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0003,
    32'h8000_0000, 32'hDEAD_BEEF, 32'h0000_FFFF, 32'hFFFF_0000};
  localparam logic [15:0] READY_PAT [NVEC] = '{
    16'hFFFF, 16'hAAAA, 16'h0F0F, 16'hFFFF,
    16'h1111, 16'h7777, 16'hFFFE, 16'h3C3C};

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load_seed(input logic [31:0] s);
    seed_load = 1; seed_value = s; step(); seed_load = 0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed",
             c_par + c_ser + n_own, f_par + f_ser + f_own);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_own++; f_own++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) step();
    rst = 0;
    // R3 reset word, R4 hold under back-pressure
    sample_ready = 0;
    repeat (3) step();
    // table walk: seeds with ready duty patterns (R1, R2, R4, R6, R7)
    for (int e = 0; e < NVEC; e++) begin
      load_seed(SEEDS[e]);
      for (int c = 0; c < 80; c++) begin
        sample_ready = READY_PAT[e][c % 16];
        step();
      end
    end
    // R5: seed strobe on the edge right after the third acceptance
    sample_ready = 0;
    load_seed(32'h0BAD_F00D);
    sample_ready = 1; repeat (3) step();
    sample_ready = 0; load_seed(32'h1357_9BDF);
    sample_ready = 1; repeat (20) step();
    // R5: seed strobe in the middle of the serial accumulation
    sample_ready = 0; load_seed(32'h2468_ACE0);
    sample_ready = 1; repeat (3) step();
    sample_ready = 0; repeat (2) step();
    load_seed(32'h0000_0004);
    sample_ready = 1; repeat (20) step();
    // R2: seeds differing only in bits 1:0 give the same first pixels
    load_seed(32'hCAFE_0000); repeat (3) step();
    load_seed(32'hCAFE_0003); repeat (10) step();
    // R3: reset in mid-stream
    rst = 1; step(); step(); rst = 0;
    sample_ready = 0; step();
    sample_ready = 1; repeat (30) step();
    sample_ready = 0; step();
    n_own++;
    if (c_par < 200 || c_ser < 200) begin
      f_own++;
      $display("FAIL R1 coverage: got %0d/%0d checks expected at least 200", c_par, c_ser);
    end
    finish_run();
  end
endmodule